// File: doc/BRIEF.md
# LCD Scan Clock Divider and COM Sequencer

This block produces the slow clock that paces an LCD panel and walks through the common-electrode phases that make up one display frame. The count source is one of two inputs. The first is a one-cycle pulse from a system prescaler. The second is a level taken from another timer, and the block counts that level's rising edges. The selected events feed a 4-bit reloadable down-counter that divides them by N+1, where N is the reload value. A toggle stage then halves the counter's underflow rate, so the LCD clock runs at source / (N+1) / 2.

Every rising edge of the LCD clock is reported as a one-cycle tick, and each tick advances the active COM index. A 2-bit duty field picks two, three or four COM phases per frame. A one-cycle frame-start pulse marks each return of the index to phase 0. The clock period is set by writing the reload value and choosing the source. The run control stops the whole chain.

Top module: `lcd_scan_clkgen`

## Requirements
- R1: With `src_sel`=1 the counter counts `pre_tick` pulses and ignores `tmr_bit`. With `src_sel`=0 it counts rising edges of `tmr_bit` and ignores `pre_tick`. An input that is not selected produces no `lcd_tick`.
- R2: While `run_en`=0 no source event is counted, `lcd_tick` stays 0, `lcd_clk` is held at 0 and `com_idx` keeps its value.
- R3: With a reload value N (0 to 15), `lcd_tick` pulses once every 2*(N+1) selected source events. Each pulse lasts one cycle.
- R4: Writing the reload value with `reload_wr` loads it into the counter at once and clears `lcd_clk` after that edge. If a prescaler pulse arrives every cycle, the first `lcd_tick` follows exactly N+2 cycles after the write edge.
- R5: The duty field encodes the number of phases per frame: `duty_sel` 00 gives 2 phases, 01 gives 3 phases, and 10 or 11 gives 4 phases. `com_idx` steps 0,1,..,n-1 and advances by one on the cycle after each `lcd_tick`.
- R6: `frame_start` is a one-cycle pulse that appears together with `com_idx` returning to 0 from n-1. Successive pulses are n LCD ticks apart.
- R7: `com_active` is the one-hot code of `com_idx`, with bit i driving COM line i. Lines at or beyond the selected phase count are never active.
- R8: A change of `duty_sel` sets `com_idx` to 0 on the next cycle without raising `frame_start`.
- R9: After reset: `lcd_clk`=0, `lcd_tick`=0, `frame_start`=0, `com_idx`=0 and `com_active`=0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Count source select: 1 = prescaler pulse, 0 = timer bit edges |
| run_en | input | 1 | 1 lets the divider count; 0 stops it and clears the toggle stage |
| pre_tick | input | 1 | One-cycle pulse from the prescaler |
| tmr_bit | input | 1 | Level from another timer; its rising edges are counted |
| reload_wr | input | 1 | Write strobe for the reload value |
| reload_data | input | CNT_W | Reload value N |
| duty_sel | input | 2 | Phases per frame (00:2, 01:3, 1x:4) |
| lcd_clk | output | 1 | Divided LCD clock level |
| lcd_tick | output | 1 | One-cycle pulse on each rising edge of lcd_clk |
| com_idx | output | 2 | Index of the active COM phase |
| com_active | output | 4 | One-hot active COM line |
| frame_start | output | 1 | One-cycle pulse when a new frame begins |

## Verification
If the down-counter holds a wrong value, the spacing between `lcd_tick` pulses shifts. The error shows within one LCD period, at most 32 source events. If the toggle stage is wrong, ticks come at the underflow rate instead of half that rate. If the phase index is wrong, it escapes the range set by the duty, or `frame_start` fires at a nonzero index or with the wrong spacing. Either fault appears within one frame, no more than four ticks. A lost duty-change restart shows as a nonzero `com_idx` one cycle after the change.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  localparam int COM_LINES = 4;
  localparam int COM_IDX_W = $clog2(COM_LINES);
  localparam int PH_W      = COM_IDX_W + 1;

  typedef enum logic {
    SRC_TMR_EDGE = 1'b0,
    SRC_PRESCALE = 1'b1
  } src_sel_e;

  // Phases per frame for a duty code: 00 -> 2, 01 -> 3, 1x -> 4
  function automatic logic [PH_W-1:0] duty_phases(input logic [1:0] code);
    case (code)
      2'b00:   duty_phases = PH_W'(2);
      2'b01:   duty_phases = PH_W'(3);
      default: duty_phases = PH_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/lcd_src_gate.sv
module lcd_src_gate
  import lcd_scan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  input  logic src_sel,
  input  logic pre_tick,
  input  logic tmr_bit,
  output logic cnt_evt
);

  logic tmr_q;
  logic tmr_rise;
  logic raw_evt;

  assign tmr_rise = tmr_bit & ~tmr_q;

  always_comb begin
    if (src_sel_e'(src_sel) == SRC_PRESCALE) raw_evt = pre_tick;
    else                                     raw_evt = tmr_rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q   <= 1'b0;
      cnt_evt <= 1'b0;
    end else begin
      tmr_q   <= tmr_bit;
      cnt_evt <= run_en & raw_evt;
    end
  end

endmodule

// File: rtl/lcd_reload_timer.sv
module lcd_reload_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cnt_evt,
  output logic             uflow
);

  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      cnt_q    <= '0;
      uflow    <= 1'b0;
    end else begin
      uflow <= 1'b0;
      if (wr) begin
        reload_q <= wr_data;
        cnt_q    <= wr_data;
      end else if (!run_en) begin
        cnt_q <= reload_q;
      end else if (cnt_evt) begin
        if (cnt_q == ZERO) begin
          cnt_q <= reload_q;
          uflow <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lcd_half_div.sv
module lcd_half_div (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic uflow,
  output logic lcd_clk,
  output logic lcd_tick
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lcd_clk  <= 1'b0;
      lcd_tick <= 1'b0;
    end else begin
      lcd_tick <= uflow & ~lcd_clk;
      if (uflow) lcd_clk <= ~lcd_clk;
    end
  end

endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan
  import lcd_scan_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic [1:0]           duty_sel,
  output logic [COM_IDX_W-1:0] com_idx,
  output logic [COM_LINES-1:0] com_active,
  output logic                 frame_start
);

  localparam logic [COM_LINES-1:0] FIRST_LINE = COM_LINES'(1);

  logic [1:0]           duty_q;
  logic [PH_W-1:0]      last_ph;
  logic                 at_last;
  logic [COM_IDX_W-1:0] idx_inc;

  assign last_ph = duty_phases(duty_q) - PH_W'(1);
  assign at_last = ({1'b0, com_idx} == last_ph);
  assign idx_inc = com_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q      <= 2'b00;
      com_idx     <= '0;
      com_active  <= FIRST_LINE;
      frame_start <= 1'b0;
    end else begin
      frame_start <= 1'b0;
      if (duty_sel != duty_q) begin
        duty_q     <= duty_sel;
        com_idx    <= '0;
        com_active <= FIRST_LINE;
      end else if (tick) begin
        if (at_last) begin
          com_idx     <= '0;
          com_active  <= FIRST_LINE;
          frame_start <= 1'b1;
        end else begin
          com_idx    <= idx_inc;
          com_active <= FIRST_LINE << idx_inc;
        end
      end
    end
  end

endmodule

// File: rtl/lcd_scan_clkgen.sv
module lcd_scan_clkgen
  import lcd_scan_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 src_sel,
  input  logic                 run_en,
  input  logic                 pre_tick,
  input  logic                 tmr_bit,
  input  logic                 reload_wr,
  input  logic [CNT_W-1:0]     reload_data,
  input  logic [1:0]           duty_sel,
  output logic                 lcd_clk,
  output logic                 lcd_tick,
  output logic [COM_IDX_W-1:0] com_idx,
  output logic [COM_LINES-1:0] com_active,
  output logic                 frame_start
);

  logic cnt_evt;
  logic uflow;
  logic div_clr;

  assign div_clr = ~run_en | reload_wr;

  lcd_src_gate u_src (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .src_sel  (src_sel),
    .pre_tick (pre_tick),
    .tmr_bit  (tmr_bit),
    .cnt_evt  (cnt_evt)
  );

  lcd_reload_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .wr      (reload_wr),
    .wr_data (reload_data),
    .cnt_evt (cnt_evt),
    .uflow   (uflow)
  );

  lcd_half_div u_half (
    .clk      (clk),
    .rst      (rst),
    .clr      (div_clr),
    .uflow    (uflow),
    .lcd_clk  (lcd_clk),
    .lcd_tick (lcd_tick)
  );

  lcd_com_scan u_scan (
    .clk         (clk),
    .rst         (rst),
    .tick        (lcd_tick),
    .duty_sel    (duty_sel),
    .com_idx     (com_idx),
    .com_active  (com_active),
    .frame_start (frame_start)
  );

endmodule

// File: rtl/lcd_scan_clkgen_chk.sv
module lcd_scan_clkgen_chk
  import lcd_scan_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 run_en,
  input logic                 reload_wr,
  input logic [1:0]           duty_sel,
  input logic                 lcd_clk,
  input logic                 lcd_tick,
  input logic [COM_IDX_W-1:0] com_idx,
  input logic                 frame_start
);

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    lcd_tick |=> !lcd_tick); // R3

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (!lcd_tick && !lcd_clk)); // R2

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    reload_wr |=> !lcd_clk); // R4

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    $stable(duty_sel) |-> ({1'b0, com_idx} < duty_phases(duty_sel))); // R5

  AST_FRAME_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (com_idx == '0)); // R6

  AST_DUTY_RESTART: assert property (@(posedge clk) disable iff (rst)
    !$stable(duty_sel) |=> (com_idx == '0 && !frame_start)); // R8

endmodule

bind lcd_scan_clkgen lcd_scan_clkgen_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .run_en      (run_en),
  .reload_wr   (reload_wr),
  .duty_sel    (duty_sel),
  .lcd_clk     (lcd_clk),
  .lcd_tick    (lcd_tick),
  .com_idx     (com_idx),
  .frame_start (frame_start)
);

// File: tb/lcd_scan_clkgen_tb.sv
`timescale 1ns/1ps
module lcd_scan_clkgen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       src_sel = 1'b1;
  logic       run_en = 1'b0;
  logic       pre_tick = 1'b0;
  logic       tmr_bit = 1'b0;
  logic       reload_wr = 1'b0;
  logic [3:0] reload_data = '0;
  logic [1:0] duty_sel = 2'b00;
  logic       lcd_clk, lcd_tick, frame_start;
  logic [1:0] com_idx;
  logic [3:0] com_active;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pdiv = 0;
  int hper = 0;
  int pcnt = 0;
  int hcnt = 0;

  always #10 clk = ~clk;

  lcd_scan_clkgen u_dut (
    .clk(clk), .rst(rst), .src_sel(src_sel), .run_en(run_en),
    .pre_tick(pre_tick), .tmr_bit(tmr_bit), .reload_wr(reload_wr),
    .reload_data(reload_data), .duty_sel(duty_sel), .lcd_clk(lcd_clk),
    .lcd_tick(lcd_tick), .com_idx(com_idx), .com_active(com_active),
    .frame_start(frame_start)
  );

  // Source stimulus, changed away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (pdiv == 0) begin
      pre_tick <= 1'b0;
      pcnt <= 0;
    end else if (pcnt >= pdiv - 1) begin
      pcnt <= 0;
      pre_tick <= 1'b1;
    end else begin
      pcnt <= pcnt + 1;
      pre_tick <= 1'b0;
    end
    if (hper == 0) begin
      tmr_bit <= 1'b0;
      hcnt <= 0;
    end else if (hcnt >= hper - 1) begin
      hcnt <= 0;
      tmr_bit <= ~tmr_bit;
    end else begin
      hcnt <= hcnt + 1;
    end
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Waits for a pulse, then returns the cycles until the next one
  task automatic gap_tick(output int gap);
    int k = 0;
    while (!lcd_tick && k < 4000) begin @(negedge clk); k++; end
    gap = 0;
    do begin @(negedge clk); gap++; end while (!lcd_tick && gap < 4000);
  endtask

  task automatic frame_scan(output int gap, output int max_idx, output int bad_hot);
    int k = 0;
    while (!frame_start && k < 8000) begin @(negedge clk); k++; end
    gap = 0; max_idx = 0; bad_hot = 0;
    do begin
      @(negedge clk); gap++;
      if (int'(com_idx) > max_idx) max_idx = int'(com_idx);
      if (com_active != (4'b0001 << com_idx)) bad_hot++;
    end while (!frame_start && gap < 8000);
    if (com_idx != 2'd0) bad_hot++;
  endtask

  task automatic setup(input logic s, input logic [3:0] n, input logic [1:0] d,
                       input int pd, input int hp);
    @(negedge clk);
    run_en = 1'b0; src_sel = s; duty_sel = d; pdiv = pd; hper = hp;
    reload_wr = 1'b1; reload_data = n;
    @(negedge clk);
    reload_wr = 1'b0;
    @(negedge clk);
    run_en = 1'b1;
  endtask

  typedef struct packed {
    logic       sel;
    logic [3:0] n;
    logic [1:0] duty;
    logic [3:0] pd;
    logic [3:0] hp;
    logic [7:0] tick_gap;
    logic [7:0] frame_gap;
    logic [2:0] phases;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 4'd0,  2'd0, 4'd1, 4'd0, 8'd2,  8'd4,   3'd2},
    '{1'b1, 4'd3,  2'd1, 4'd1, 4'd0, 8'd8,  8'd24,  3'd3},
    '{1'b1, 4'd1,  2'd2, 4'd3, 4'd0, 8'd12, 8'd48,  3'd4},
    '{1'b0, 4'd2,  2'd3, 4'd0, 4'd2, 8'd24, 8'd96,  3'd4},
    '{1'b1, 4'd15, 2'd2, 4'd1, 4'd0, 8'd32, 8'd128, 3'd4},
    '{1'b0, 4'd0,  2'd1, 4'd0, 4'd1, 8'd4,  8'd12,  3'd3}
  };

  initial begin
    int g, mx, bad, cnt, held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 lcd_clk", int'(lcd_clk), 0);
    check("R9 lcd_tick", int'(lcd_tick), 0);
    check("R9 frame_start", int'(frame_start), 0);
    check("R9 com_idx", int'(com_idx), 0);
    check("R9 com_active", int'(com_active), 1);

    // Table of source / divider / duty settings (R1 R3 R5 R6 R7)
    for (int i = 0; i < 6; i++) begin
      setup(VECS[i].sel, VECS[i].n, VECS[i].duty, int'(VECS[i].pd), int'(VECS[i].hp));
      gap_tick(g);
      check("R3 tick spacing", g, int'(VECS[i].tick_gap));
      frame_scan(g, mx, bad);
      check("R6 frame spacing", g, int'(VECS[i].frame_gap));
      check("R5 last phase", mx, int'(VECS[i].phases) - 1);
      check("R7 one-hot COM", bad, 0);
    end

    // R2: stopped chain gives no tick, clock low, index held
    setup(1'b1, 4'd0, 2'd2, 1, 0);
    repeat (5) @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    held = int'(com_idx); cnt = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (lcd_tick || lcd_clk || int'(com_idx) != held) cnt++;
    end
    check("R2 stopped activity", cnt, 0);

    // R1: unselected source ignored (timer bit selected but flat)
    setup(1'b0, 4'd0, 2'd0, 1, 0);
    cnt = 0;
    for (int k = 0; k < 200; k++) begin @(negedge clk); if (lcd_tick) cnt++; end
    check("R1 prescaler ignored", cnt, 0);
    // R1: prescaler selected but silent while timer bit toggles
    setup(1'b1, 4'd0, 2'd0, 0, 1);
    cnt = 0;
    for (int k = 0; k < 200; k++) begin @(negedge clk); if (lcd_tick) cnt++; end
    check("R1 timer bit ignored", cnt, 0);

    // R4: reload write mid-run restarts the divider
    setup(1'b1, 4'd7, 2'd2, 1, 0);
    repeat (13) @(negedge clk);
    reload_wr = 1'b1; reload_data = 4'd3;
    @(negedge clk);
    reload_wr = 1'b0;
    check("R4 clock cleared", int'(lcd_clk), 0);
    cnt = 0;
    while (!lcd_tick && cnt < 50) begin @(negedge clk); cnt++; end
    check("R4 first tick delay", cnt, 5);

    // R8: duty change restarts the phase index without a frame pulse
    setup(1'b1, 4'd0, 2'd2, 1, 0);
    cnt = 0;
    while (com_idx != 2'd2 && cnt < 100) begin @(negedge clk); cnt++; end
    duty_sel = 2'b00;
    @(negedge clk);
    check("R8 index restart", int'(com_idx), 0);
    check("R8 no frame pulse", int'(frame_start), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule